// File: doc/BRIEF.md
# Exclusive Three-Cache Request Dispatcher

This block sits in front of a cache complex made of an instruction L1, a data L1 and an L2. No block is ever held in more than one of the three. For the request at the head of the processor request queue (load, fetch, store or atomic), it picks the one internal event to run next and the address that event works on. Tag storage, data movement and coherence traffic belong to other blocks. The dispatcher only looks at tag-presence, free-way and victim-address signals and chooses the action.

A request may first need preparatory events before its own event can run. If the block sits in the wrong L1, it is pushed into the L2. If the right L1 is full, that L1's victim is moved into the L2. If the L2 has no room for what must go into it, an L2 victim is evicted, chosen by the address being placed. The block drives a probe address to the L2 so that the L2's free-way and victim answers refer to the address that matters at that moment. The request leaves the queue only when its own event is accepted. A one-entry event register holds each decision stable until the downstream side accepts it. After each handshake the next decision is made from the tag state present at that time.

Top module: `tri_cache_dispatch`

## Requirements
- R1: While reset is asserted and after its release with no request, evt_valid_o and req_pop_o are low.
- R2: Request kinds are encoded 0 load, 1 fetch, 2 store, 3 atomic. When the block is in the matching L1 (instruction L1 for fetch, data L1 otherwise) and not in the other L1, the event is load (code 0), fetch (code 1) or store (code 2, also for atomic), at the request address.
- R3: When the other L1 holds the block, l2_probe_addr_o is the request address. The event is L1-to-L2 (code 3) at the request address if l2_free_i is high. Otherwise it is L2 eviction (code 6) at l2_victim_i.
- R4: When neither L1 holds the block and the matching L1 has a free way: if l2_hit_i is high, the event is L2-to-data-L1 (code 4) or, for a fetch, L2-to-instruction-L1 (code 5), at the request address. Otherwise it is the normal miss event of R2.
- R5: When neither L1 holds the block and the matching L1 has no free way, l2_probe_addr_o is that L1's victim address. The event is L1-to-L2 (code 3) at that victim address if l2_free_i is high. Otherwise it is L2 eviction (code 6) at l2_victim_i.
- R6: req_pop_o is high only in a cycle where evt_valid_o and evt_ready_i are both high and the code is 0, 1 or 2. Migration and eviction events never pop the request.
- R7: While evt_valid_o is high and evt_ready_i is low, evt_valid_o, evt_code_o and evt_addr_o stay unchanged in the next cycle.
- R8: The cycle after a handshake, evt_valid_o is low. A new decision appears one cycle later if a request is still present.
- R9: lookup_src_o gives where the block is, by priority: 1 for the L2, then 2 for the data L1, then 3 for the instruction L1, and 0 when no cache reports a hit.
- R10: multi_hit_o is high exactly when more than one of the three hit inputs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A request is at the head of the queue |
| req_kind_i | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr_i | input | ADDR_W | Request block address |
| req_pop_o | output | 1 | Remove the head request |
| l1i_hit_i | input | 1 | Instruction L1 holds the request block |
| l1d_hit_i | input | 1 | Data L1 holds the request block |
| l2_hit_i | input | 1 | L2 holds the request block |
| l1i_free_i | input | 1 | Instruction L1 set of the request has a free way |
| l1d_free_i | input | 1 | Data L1 set of the request has a free way |
| l1i_victim_i | input | ADDR_W | Instruction L1 victim for the request set |
| l1d_victim_i | input | ADDR_W | Data L1 victim for the request set |
| l2_probe_addr_o | output | ADDR_W | Address whose L2 set is probed |
| l2_free_i | input | 1 | L2 set of the probe address has a free way |
| l2_victim_i | input | ADDR_W | L2 victim for the probe address |
| evt_valid_o | output | 1 | Event decision valid |
| evt_ready_i | input | 1 | Downstream accepts the event |
| evt_code_o | output | 3 | Event code |
| evt_addr_o | output | ADDR_W | Event target address |
| lookup_src_o | output | 2 | Cache holding the block |
| multi_hit_o | output | 1 | More than one cache reports a hit |

## Verification
The bench sweeps every request kind against every combination of the three hit bits, both L1 free bits, the L2 hit bit and the L2 free bit, and predicts the event from the rules. A design that checked the matching L1 before the other L1 would issue a normal event while the block was stranded in the wrong L1. A design that probed the L2 with the request address on a full L1 would evict or migrate the wrong line. A design that popped on a migration event would drop the request before its own event ran. The sweep also holds the ready line low to catch decisions that drift while stalled. It checks the idle cycle after each handshake, since missing it would act on stale tag state.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [2:0] {
    EV_LOAD      = 3'd0,
    EV_FETCH     = 3'd1,
    EV_STORE     = 3'd2,
    EV_L1_TO_L2  = 3'd3,
    EV_L2_TO_L1D = 3'd4,
    EV_L2_TO_L1I = 3'd5,
    EV_L2_EVICT  = 3'd6
  } evt_e;

  typedef enum logic [1:0] {
    RQ_LOAD   = 2'd0,
    RQ_FETCH  = 2'd1,
    RQ_STORE  = 2'd2,
    RQ_ATOMIC = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_L2   = 2'd1,
    SRC_L1D  = 2'd2,
    SRC_L1I  = 2'd3
  } src_e;
endpackage

// File: rtl/tcd_side_sel.sv
// Maps the request kind onto the matching / opposite L1.
module tcd_side_sel
  import tcd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        kind_i,
  input  logic              l1i_hit_i,
  input  logic              l1d_hit_i,
  input  logic              l1i_free_i,
  input  logic              l1d_free_i,
  input  logic [ADDR_W-1:0] l1i_victim_i,
  input  logic [ADDR_W-1:0] l1d_victim_i,
  output logic              own_hit_o,
  output logic              other_hit_o,
  output logic              own_free_o,
  output logic [ADDR_W-1:0] own_victim_o,
  output evt_e              normal_evt_o,
  output evt_e              fill_evt_o
);
  req_e kind;
  logic is_fetch;

  assign kind     = req_e'(kind_i);
  assign is_fetch = (kind == RQ_FETCH);

  always_comb begin
    if (is_fetch) begin
      own_hit_o    = l1i_hit_i;
      other_hit_o  = l1d_hit_i;
      own_free_o   = l1i_free_i;
      own_victim_o = l1i_victim_i;
      fill_evt_o   = EV_L2_TO_L1I;
    end else begin
      own_hit_o    = l1d_hit_i;
      other_hit_o  = l1i_hit_i;
      own_free_o   = l1d_free_i;
      own_victim_o = l1d_victim_i;
      fill_evt_o   = EV_L2_TO_L1D;
    end
  end

  always_comb begin
    unique case (kind)
      RQ_LOAD:  normal_evt_o = EV_LOAD;
      RQ_FETCH: normal_evt_o = EV_FETCH;
      default:  normal_evt_o = EV_STORE; // store and atomic
    endcase
  end
endmodule

// File: rtl/tcd_lookup.sv
// Priority source resolution and multi-hit detection over NC caches.
module tcd_lookup
  import tcd_pkg::*;
#(
  parameter int NC = 3
) (
  input  logic [NC-1:0] hit_vec_i, // [0]=L2, [1]=L1D, [2]=L1I
  output src_e          src_o,
  output logic          multi_o
);
  localparam int CW = $clog2(NC + 1);

  logic [CW-1:0] cnt;
  logic [1:0]    first_idx;
  logic          any_hit;

  always_comb begin
    cnt       = '0;
    first_idx = '0;
    any_hit   = 1'b0;
    for (int i = NC - 1; i >= 0; i--) begin
      cnt = cnt + CW'(hit_vec_i[i]);
      if (hit_vec_i[i]) begin
        first_idx = 2'(i);
        any_hit   = 1'b1;
      end
    end
  end

  assign src_o   = any_hit ? src_e'(first_idx + 2'd1) : SRC_NONE;
  assign multi_o = (cnt > CW'(1));
endmodule

// File: rtl/tcd_decide.sv
// Chooses the next event and its target, and the L2 probe address.
module tcd_decide
  import tcd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              own_hit_i,
  input  logic              other_hit_i,
  input  logic              own_free_i,
  input  logic [ADDR_W-1:0] own_victim_i,
  input  evt_e              normal_evt_i,
  input  evt_e              fill_evt_i,
  input  logic              l2_hit_i,
  input  logic              l2_free_i,
  input  logic [ADDR_W-1:0] l2_victim_i,
  output logic [ADDR_W-1:0] probe_addr_o,
  output evt_e              evt_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic              consume_o
);
  logic need_victim;

  // Only a full matching L1 with no L1 copy needs the L1 victim probed.
  assign need_victim  = !other_hit_i && !own_hit_i && !own_free_i;
  assign probe_addr_o = need_victim ? own_victim_i : req_addr_i;

  always_comb begin
    evt_o      = normal_evt_i;
    evt_addr_o = req_addr_i;
    if (other_hit_i || need_victim) begin
      if (l2_free_i) begin
        evt_o      = EV_L1_TO_L2;
        evt_addr_o = probe_addr_o;
      end else begin
        evt_o      = EV_L2_EVICT;
        evt_addr_o = l2_victim_i;
      end
    end else if (!own_hit_i && l2_hit_i) begin
      evt_o = fill_evt_i;
    end
  end

  assign consume_o = (evt_o == EV_LOAD) || (evt_o == EV_FETCH) || (evt_o == EV_STORE);
endmodule

// File: rtl/tri_cache_dispatch.sv
module tri_cache_dispatch
  import tcd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_pop_o,
  input  logic              l1i_hit_i,
  input  logic              l1d_hit_i,
  input  logic              l2_hit_i,
  input  logic              l1i_free_i,
  input  logic              l1d_free_i,
  input  logic [ADDR_W-1:0] l1i_victim_i,
  input  logic [ADDR_W-1:0] l1d_victim_i,
  output logic [ADDR_W-1:0] l2_probe_addr_o,
  input  logic              l2_free_i,
  input  logic [ADDR_W-1:0] l2_victim_i,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [2:0]        evt_code_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [1:0]        lookup_src_o,
  output logic              multi_hit_o
);
  localparam int NCACHE = 3;

  logic              own_hit, other_hit, own_free, consume_d;
  logic [ADDR_W-1:0] own_victim, next_addr;
  evt_e              normal_evt, fill_evt, next_evt;
  src_e              src;

  tcd_side_sel #(.ADDR_W(ADDR_W)) u_side (
    .kind_i       (req_kind_i),
    .l1i_hit_i    (l1i_hit_i),
    .l1d_hit_i    (l1d_hit_i),
    .l1i_free_i   (l1i_free_i),
    .l1d_free_i   (l1d_free_i),
    .l1i_victim_i (l1i_victim_i),
    .l1d_victim_i (l1d_victim_i),
    .own_hit_o    (own_hit),
    .other_hit_o  (other_hit),
    .own_free_o   (own_free),
    .own_victim_o (own_victim),
    .normal_evt_o (normal_evt),
    .fill_evt_o   (fill_evt)
  );

  tcd_decide #(.ADDR_W(ADDR_W)) u_decide (
    .req_addr_i   (req_addr_i),
    .own_hit_i    (own_hit),
    .other_hit_i  (other_hit),
    .own_free_i   (own_free),
    .own_victim_i (own_victim),
    .normal_evt_i (normal_evt),
    .fill_evt_i   (fill_evt),
    .l2_hit_i     (l2_hit_i),
    .l2_free_i    (l2_free_i),
    .l2_victim_i  (l2_victim_i),
    .probe_addr_o (l2_probe_addr_o),
    .evt_o        (next_evt),
    .evt_addr_o   (next_addr),
    .consume_o    (consume_d)
  );

  tcd_lookup #(.NC(NCACHE)) u_lookup (
    .hit_vec_i ({l1i_hit_i, l1d_hit_i, l2_hit_i}),
    .src_o     (src),
    .multi_o   (multi_hit_o)
  );

  assign lookup_src_o = src;

  // One-entry decision register; empty for one cycle after each handshake
  // so the next decision sees tag state updated by the accepted event.
  logic              vld_q, consume_q;
  evt_e              evt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fire;

  assign fire = vld_q && evt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      consume_q <= 1'b0;
      evt_q     <= EV_LOAD;
      addr_q    <= '0;
    end else if (fire) begin
      vld_q     <= 1'b0;
    end else if (!vld_q && req_valid_i) begin
      vld_q     <= 1'b1;
      consume_q <= consume_d;
      evt_q     <= next_evt;
      addr_q    <= next_addr;
    end
  end

  assign evt_valid_o = vld_q;
  assign evt_code_o  = evt_q;
  assign evt_addr_o  = addr_q;
  assign req_pop_o   = fire && consume_q;
endmodule

// File: rtl/tri_cache_dispatch_chk.sv
module tri_cache_dispatch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_pop_o,
  input logic              l1i_hit_i,
  input logic              l1d_hit_i,
  input logic              l2_hit_i,
  input logic              evt_valid_o,
  input logic              evt_ready_i,
  input logic [2:0]        evt_code_o,
  input logic [ADDR_W-1:0] evt_addr_o,
  input logic [1:0]        lookup_src_o,
  input logic              multi_hit_o
);
  assert_pop_own_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_pop_o |-> (evt_valid_o && evt_ready_i && evt_code_o <= 3'd2));

  assert_no_pop_migrate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_code_o >= 3'd3) |-> !req_pop_o);

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i) |=>
      (evt_valid_o && $stable(evt_code_o) && $stable(evt_addr_o)));

  assert_gap_after_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_ready_i) |=> !evt_valid_o);

  assert_idle_stays_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_o && !req_valid_i) |=> !evt_valid_o);

  assert_code_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (evt_code_o != 3'd7));

  assert_l2_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_hit_i |-> (lookup_src_o == 2'd1));

  assert_none_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l2_hit_i || l1d_hit_i || l1i_hit_i) |-> (lookup_src_o == 2'd0));

  assert_both_l1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1i_hit_i && l1d_hit_i) |-> multi_hit_o);

  assert_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l2_hit_i, l1d_hit_i, l1i_hit_i}) |-> !multi_hit_o);
endmodule

bind tri_cache_dispatch tri_cache_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_pop_o    (req_pop_o),
  .l1i_hit_i    (l1i_hit_i),
  .l1d_hit_i    (l1d_hit_i),
  .l2_hit_i     (l2_hit_i),
  .evt_valid_o  (evt_valid_o),
  .evt_ready_i  (evt_ready_i),
  .evt_code_o   (evt_code_o),
  .evt_addr_o   (evt_addr_o),
  .lookup_src_o (lookup_src_o),
  .multi_hit_o  (multi_hit_o)
);

// File: tb/tri_cache_dispatch_test.sv
`timescale 1ns/1ps
module tri_cache_dispatch_test;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    req_kind_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_pop_o;
  logic          l1i_hit_i = 1'b0, l1d_hit_i = 1'b0, l2_hit_i = 1'b0;
  logic          l1i_free_i = 1'b0, l1d_free_i = 1'b0;
  logic [AW-1:0] l1i_victim_i = '0, l1d_victim_i = '0;
  logic [AW-1:0] l2_probe_addr_o;
  logic          l2_free_i = 1'b0;
  logic [AW-1:0] l2_victim_i = '0;
  logic          evt_valid_o;
  logic          evt_ready_i = 1'b0;
  logic [2:0]    evt_code_o;
  logic [AW-1:0] evt_addr_o;
  logic [1:0]    lookup_src_o;
  logic          multi_hit_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i; // 250 MHz

  tri_cache_dispatch #(.ADDR_W(AW)) uut (.*);

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input int kind, input int hits, input int frees);
    logic fetch, own_hit, oth_hit, own_free;
    logic [AW-1:0] own_vic, exp_probe, exp_addr;
    int exp_code, exp_src, nh;
    bit cons;

    @(negedge clk_i);
    req_kind_i   = 2'(kind);
    l2_hit_i     = hits[0];
    l1d_hit_i    = hits[1];
    l1i_hit_i    = hits[2];
    l1i_free_i   = frees[0];
    l1d_free_i   = frees[1];
    l2_free_i    = frees[2];
    req_addr_i   = 32'h1000_0000 | AW'(kind * 256 + hits * 16 + frees);
    l1i_victim_i = 32'h2000_0000 | AW'(hits * 16 + frees);
    l1d_victim_i = 32'h3000_0000 | AW'(hits * 16 + frees);
    l2_victim_i  = 32'h4000_0000 | AW'(kind * 256 + hits * 16 + frees);
    req_valid_i  = 1'b1;
    evt_ready_i  = 1'b0;

    fetch    = (kind == 1);
    own_hit  = fetch ? l1i_hit_i : l1d_hit_i;
    oth_hit  = fetch ? l1d_hit_i : l1i_hit_i;
    own_free = fetch ? l1i_free_i : l1d_free_i;
    own_vic  = fetch ? l1i_victim_i : l1d_victim_i;
    exp_probe = req_addr_i;
    exp_addr  = req_addr_i;
    exp_code  = (kind == 0) ? 0 : (kind == 1) ? 1 : 2;
    if (oth_hit) begin
      exp_code = l2_free_i ? 3 : 6;
      exp_addr = l2_free_i ? req_addr_i : l2_victim_i;
    end else if (own_hit) begin
    end else if (own_free) begin
      if (l2_hit_i) exp_code = fetch ? 5 : 4;
    end else begin
      exp_probe = own_vic;
      exp_code  = l2_free_i ? 3 : 6;
      exp_addr  = l2_free_i ? own_vic : l2_victim_i;
    end
    cons = (exp_code <= 2);
    exp_src = l2_hit_i ? 1 : l1d_hit_i ? 2 : l1i_hit_i ? 3 : 0;
    nh = int'(l2_hit_i) + int'(l1d_hit_i) + int'(l1i_hit_i);

    #1;
    // probe address belongs to R3 (wrong L1) or R5 (full L1)
    check(oth_hit ? "R3 probe" : "R5 probe", l2_probe_addr_o, exp_probe);
    check("R9 lookup_src", AW'(lookup_src_o), AW'(exp_src));
    check("R10 multi_hit", AW'(multi_hit_o), AW'(nh > 1));
    check("R8 empty before decide", AW'(evt_valid_o), 0);

    @(negedge clk_i);
    check("R8 valid after decide", AW'(evt_valid_o), 1);
    if (oth_hit) begin
      check("R3 code", AW'(evt_code_o), AW'(exp_code));
      check("R3 addr", evt_addr_o, exp_addr);
    end else if (own_hit) begin
      check("R2 code", AW'(evt_code_o), AW'(exp_code));
      check("R2 addr", evt_addr_o, exp_addr);
    end else if (own_free) begin
      check("R4 code", AW'(evt_code_o), AW'(exp_code));
      check("R4 addr", evt_addr_o, exp_addr);
    end else begin
      check("R5 code", AW'(evt_code_o), AW'(exp_code));
      check("R5 addr", evt_addr_o, exp_addr);
    end
    check("R6 no pop without ready", AW'(req_pop_o), 0);

    @(negedge clk_i);
    check("R7 held valid", AW'(evt_valid_o), 1);
    check("R7 held code", AW'(evt_code_o), AW'(exp_code));
    check("R7 held addr", evt_addr_o, exp_addr);
    evt_ready_i = 1'b1;
    #1;
    check("R6 pop on handshake", AW'(req_pop_o), AW'(cons));

    @(negedge clk_i);
    evt_ready_i = 1'b0;
    req_valid_i = 1'b0;
    #1;
    check("R8 gap after handshake", AW'(evt_valid_o), 0);
    check("R6 no pop in gap", AW'(req_pop_o), 0);
  endtask

  initial begin
    #1;
    check("R1 reset valid", AW'(evt_valid_o), 0);
    check("R1 reset pop", AW'(req_pop_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle valid", AW'(evt_valid_o), 0);
    check("R1 idle pop", AW'(req_pop_o), 0);

    for (int k = 0; k < 4; k++)
      for (int h = 0; h < 8; h++)
        for (int f = 0; f < 8; f++)
          run_case(k, h, f);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule